// File: doc/BRIEF.md
# Frame Pulse Sync Aligner

This block produces an output frame pulse that is one output-clock cycle wide. The pulse repeats at a programmable frame length, counted in output clock cycles. The block can also align the phase of that pulse to an external frame-pulse sync input. Three sync lines come in, and the line that counts is the one whose index equals the active reference index. The block has no part in frequency lock. It only decides on which output clock edge the frame pulse falls.

Each sync line passes through its own synchronizer chain and then a rising-edge detector. When a rising edge arrives on the selected line and alignment is enabled, the frame counter restarts at once. The next output pulse then sits on the output clock edge that corresponds to the incoming pulse. With no sync edge, the counter free-runs and the pulse keeps whatever phase it already has. A presence flag reports whether the selected line has produced a rising edge within the last two frame lengths.

Top module: `fp_sync_aligner`

## Requirements
- R1: In free-run, `frame_pulse` is high for exactly one cycle every L cycles. L is `frame_len`, except that a `frame_len` of 0 or 1 is treated as 2.
- R2: While `rst_n` is low, `frame_pulse` and `sync_present` are 0. After `rst_n` rises, the first pulse is visible after the L-th rising clock edge.
- R3: With `align_en` = 1, suppose sync line n rises while `ref_sel` = n (n = 0, 1 or 2). The first rising clock edge that sees the high level is edge 1. `frame_pulse` is then high after edge 3, and the pulses that follow are L cycles apart from that one.
- R4: Only a rising edge of the selected sync line counts. Holding it high for several frames, or letting it fall, leaves the pulse phase unchanged.
- R5: Rising edges on the sync lines whose index differs from `ref_sel` do not change the pulse phase.
- R6: With `align_en` = 0, a rising edge on the selected line leaves the pulse phase unchanged, but it still sets `sync_present`.
- R7: `sync_present` is set in the same cycle that an R3 realignment would assert the pulse. After that rising edge of the clock, it clears at the 2L-th rising edge, provided no further selected sync edge has arrived.
- R8: A `ref_sel` value of 3 or above selects no sync line, so sync edges then have no effect on either output.
- R9: Suppose a realignment lands in the cycle where the free-running counter would have wrapped anyway. The block then gives a single one-cycle pulse, and the next pulse follows L cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_len | input | CNT_W | Frame length in output clock cycles (values below 2 mean 2) |
| ref_sel | input | SEL_W | Active reference index; picks the paired sync line |
| align_en | input | 1 | Allows a selected sync edge to realign the frame counter |
| sync_in | input | NUM_SYNC | Asynchronous frame-pulse sync lines, one per reference |
| frame_pulse | output | 1 | One-cycle output frame pulse |
| sync_present | output | 1 | Selected sync line produced a rising edge within the last 2L cycles |

## Verification
A realignment reload and the counter's own wrap can fall in the same cycle. The bench provokes this by sweeping the arrival of the sync edge across every phase offset of the frame, for each of the three sync lines. A reference phase model in the bench predicts the pulse for every cycle. The bench requires a single pulse at the realigned position, and it requires the next pulse exactly L cycles later, with no doubled or missing pulse. A second overlap, a fresh edge arriving just as the presence window runs out, is judged by `sync_present` staying set.

// File: rtl/fp_sync_pkg.sv
package fp_sync_pkg;
   localparam int MIN_FRAME_LEN   = 2;
   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/fp_sync_edge.sv
module fp_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/fp_frame_ctr.sv
module fp_frame_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] frame_eff,
   input  logic             reload,
   output logic             pulse,
   output logic [CNT_W-1:0] cnt
);
   logic wrap;

   assign wrap = (cnt >= (frame_eff - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (reload || wrap) begin
         cnt   <= '0;
         pulse <= 1'b1;
      end else begin
         cnt   <= cnt + CNT_W'(1);
         pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/fp_sync_watch.sv
module fp_sync_watch #(
   parameter int CNT_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CNT_W-1:0] frame_eff,
   input  logic           edge_seen,
   output logic           present,
   output logic [CNT_W:0] gap
);
   localparam int GW = CNT_W + 1;

   logic [GW-1:0] window_m1;

   assign window_m1 = ({1'b0, frame_eff} << 1) - GW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap     <= '0;
         present <= 1'b0;
      end else if (edge_seen) begin
         gap     <= '0;
         present <= 1'b1;
      end else if (gap >= window_m1) begin
         present <= 1'b0;
      end else begin
         gap <= gap + GW'(1);
      end
   end
endmodule

// File: rtl/fp_sync_aligner.sv
module fp_sync_aligner
   import fp_sync_pkg::*;
#(
   parameter int NUM_SYNC    = 3,
   parameter int SEL_W       = 2,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    frame_len,
   input  logic [SEL_W-1:0]    ref_sel,
   input  logic                align_en,
   input  logic [NUM_SYNC-1:0] sync_in,
   output logic                frame_pulse,
   output logic                sync_present
);
   localparam int PAD_W = 2 ** SEL_W;

   if (NUM_SYNC < 1 || NUM_SYNC > PAD_W) begin : g_bad_num
      $error("NUM_SYNC must lie between 1 and 2**SEL_W");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("SYNC_STAGES below the minimum synchronizer depth");
   end

   logic [NUM_SYNC-1:0] rise_vec;
   logic [PAD_W-1:0]    rise_pad;
   logic                sel_edge;
   logic                reload;
   logic [CNT_W-1:0]    frame_eff;
   logic [CNT_W-1:0]    frame_cnt;
   logic [CNT_W:0]      gap_cnt;

   for (genvar i = 0; i < NUM_SYNC; i++) begin : g_line
      fp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (sync_in[i]),
         .rise (rise_vec[i])
      );
   end

   assign rise_pad  = PAD_W'(rise_vec);
   assign sel_edge  = rise_pad[ref_sel];
   assign reload    = sel_edge & align_en;
   assign frame_eff = (frame_len < CNT_W'(MIN_FRAME_LEN)) ? CNT_W'(MIN_FRAME_LEN) : frame_len;

   fp_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_eff(frame_eff),
      .reload   (reload),
      .pulse    (frame_pulse),
      .cnt      (frame_cnt)
   );

   fp_sync_watch #(.CNT_W(CNT_W)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_eff(frame_eff),
      .edge_seen(sel_edge),
      .present  (sync_present),
      .gap      (gap_cnt)
   );
endmodule

// File: rtl/fp_sync_aligner_chk.sv
module fp_sync_aligner_chk #(
   parameter int NUM_SYNC = 3,
   parameter int SEL_W    = 2,
   parameter int CNT_W    = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             align_en,
   input logic [SEL_W-1:0] ref_sel,
   input logic             frame_pulse,
   input logic             sync_present,
   input logic             sel_edge,
   input logic [CNT_W-1:0] frame_eff,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W:0]   gap
);
   // R1: a counter at its last position wraps and emits the pulse
   a_r1_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= frame_eff - CNT_W'(1)) |=> (frame_pulse && cnt == '0));

   // R4: no pulse away from a wrap or a reload
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!(sel_edge && align_en) && cnt < frame_eff - CNT_W'(1)) |=> !frame_pulse);

   // R3: a reload gives the pulse on the next edge with the counter restarted
   a_r3_realign: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_edge && align_en) |=> (frame_pulse && cnt == '0));

   // R7: presence only rises after a selected edge
   a_r7_present_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_present) |-> $past(sel_edge));

   // R7: presence only falls once the window has run out
   a_r7_present_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_present) |->
         ($past(gap) >= (({1'b0, $past(frame_eff)} << 1) - (CNT_W+1)'(1))));

   // R8: an index past the last line selects nothing
   a_r8_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ref_sel) >= NUM_SYNC) |-> !sel_edge);
endmodule

bind fp_sync_aligner fp_sync_aligner_chk #(
   .NUM_SYNC(NUM_SYNC), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .align_en    (align_en),
   .ref_sel     (ref_sel),
   .frame_pulse (frame_pulse),
   .sync_present(sync_present),
   .sel_edge    (sel_edge),
   .frame_eff   (frame_eff),
   .cnt         (frame_cnt),
   .gap         (gap_cnt)
);

// File: tb/sim_fp_sync_aligner.sv
`timescale 1ns/1ps
module sim_fp_sync_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] frame_len = 12'd5;
   logic [1:0]  ref_sel = 2'd0;
   logic        align_en = 1'b1;
   logic [2:0]  sync_in = 3'b000;
   logic        frame_pulse;
   logic        sync_present;

   int checks = 0;
   int errors = 0;
   int eff = 5;
   int ph = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fp_sync_aligner u0 (
      .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .ref_sel(ref_sel),
      .align_en(align_en), .sync_in(sync_in),
      .frame_pulse(frame_pulse), .sync_present(sync_present)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (eff %0d)", tag, act, exp, eff);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // advance n cycles, checking the pulse against the phase model
   task automatic run_expect(int n, string tag);
      for (int i = 0; i < n; i++) begin
         cyc();
         ph = (ph + 1) % eff;
         chk(tag, int'(frame_pulse), (ph == 0) ? 1 : 0);
      end
   endtask

   task automatic do_reset(int len);
      rst_n = 1'b0;
      sync_in = 3'b000;
      frame_len = 12'(len);
      eff = (len < 2) ? 2 : len;
      cyc(); cyc();
      chk("R2 pulse in reset", int'(frame_pulse), 0);
      chk("R2 present in reset", int'(sync_present), 0);
      rst_n = 1'b1;
      ph = 0;
   endtask

   // raise the selected line; realigned pulse after the third edge
   task automatic align_on(int sel, string tag);
      sync_in[sel] = 1'b1;
      run_expect(2, tag);
      cyc();
      chk(tag, int'(frame_pulse), 1);
      chk("R7 present set", int'(sync_present), 1);
      ph = 0;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 / R2: free-run sweep over frame lengths, including clamped ones
      for (int len = 0; len <= 7; len++) begin
         do_reset(len);
         run_expect(3 * eff, "R1 free-run period");
      end

      do_reset(5);
      align_en = 1'b1;
      // R3 / R9: every line, every arrival phase (includes wrap collisions)
      for (int sel = 0; sel < 3; sel++) begin
         ref_sel = 2'(sel);
         for (int off = 0; off < eff; off++) begin
            run_expect(off, "R3 R9 pre");
            align_on(sel, "R3 R9 realign");
            run_expect(eff + 2, "R4 held high");
            sync_in = 3'b000;
            run_expect(eff, "R4 falling edge");
         end
      end

      // R5: unselected lines ignored
      ref_sel = 2'd0;
      run_expect(2, "R5 pre");
      sync_in = 3'b110;
      run_expect(3 * eff, "R5 other lines");
      sync_in = 3'b000;
      run_expect(eff, "R5 after");

      // R6: alignment disabled, presence still tracked
      do_reset(5);
      ref_sel = 2'd1;
      align_en = 1'b0;
      run_expect(1, "R6 pre");
      sync_in[1] = 1'b1;
      run_expect(3, "R6 no realign");
      chk("R6 present tracked", int'(sync_present), 1);
      run_expect(eff, "R6 no realign");
      sync_in = 3'b000;
      align_en = 1'b1;

      // R8: out-of-range index
      do_reset(4);
      ref_sel = 2'd3;
      run_expect(1, "R8 pre");
      sync_in = 3'b111;
      run_expect(3 * eff, "R8 no select");
      chk("R8 present clear", int'(sync_present), 0);
      sync_in = 3'b000;
      run_expect(3, "R8 after");

      // R7: presence window of 2L cycles
      ref_sel = 2'd2;
      align_on(2, "R7 realign");
      sync_in = 3'b000;
      for (int k = 1; k <= 2 * eff; k++) begin
         run_expect(1, "R7 phase");
         chk("R7 present window", int'(sync_present), (k < 2 * eff) ? 1 : 0);
      end
      run_expect(eff, "R7 free-run after loss");
      chk("R7 stays absent", int'(sync_present), 0);
      align_on(2, "R7 reacquire");
      sync_in = 3'b000;
      // R7: an edge at the last window cycle keeps presence set
      run_expect(2 * eff - 4, "R7 late edge phase");
      sync_in[2] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         cyc();
         ph = (ph + 1) % eff;
         chk("R7 late edge present", int'(sync_present), 1);
      end
      ph = 0;
      chk("R7 late edge realign", int'(frame_pulse), 1);
      sync_in = 3'b000;
      run_expect(eff, "R7 late edge period");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule